// File: doc/BRIEF.md
# I2C Transmit/Receive Byte FIFOs with Trigger-Level Interrupts

This block holds the two byte queues that sit between the software-facing side of an I2C controller and its bus protocol engine. Software fills the transmit queue and drains the receive queue through a small register port. The engine takes transmit bytes and deposits receive bytes through a pair of single-cycle strobes. The bus protocol itself and clock generation are outside this block.

Each queue has its own enable and its own 7-bit trigger level. The block raises seven interrupt causes, which are kept in a sticky status register that is cleared by writing ones. The causes are: transmit running low, receive filling up, underrun and overrun on each queue, and a trailing-data timeout. The trailing timeout lets software collect a short tail of received bytes that never reaches the receive trigger. A single interrupt line is the OR of the status bits that the enable mask lets through.

Register reads return data one cycle after the read strobe. A read of the receive data register removes a byte from the receive queue, and a write of the transmit data register adds a byte to the transmit queue.

Top module: `i2c_byte_fifos`

## Requirements
- R1: After reset both queues are disabled and empty. The queue status word (address 3) reads 32'h0100_0100. The interrupt status (address 2) and the control word (address 0) read 0, and `irq` is low.
- R2: Bytes leave each queue in the order they entered. Address 3 reports the transmit level in bits [6:0], transmit full in bit 7 and transmit empty in bit 8. It reports the receive level in bits [22:16], receive full in bit 23 and receive empty in bit 24.
- R3: The control word (address 0) holds the receive enable in bit 0, the transmit enable in bit 1, the receive trigger in bits [10:4] and the transmit trigger in bits [22:16]. Status bit 0 (transmit low) is set in every cycle in which the transmit queue is enabled and its level is at or below the transmit trigger.
- R4: Status bit 1 (receive high) is set in every cycle in which the receive queue is enabled and its level is at or above the receive trigger.
- R5: A byte pushed into a full queue is dropped and the level stays at the depth. A transmit-data write (address 4) to a full queue sets bit 3. An engine push to a full receive queue sets bit 5.
- R6: A pop from an empty enabled queue returns 8'h00. An engine pop of the transmit queue sets bit 2. A receive-data read (address 5) sets bit 4.
- R7: The trailing count is written to address 6, bits [3:0], as the value T. When the receive queue is enabled and holds more than zero bytes but fewer than the trigger, status bit 6 is set at the (T+1)th clock edge after the last receive push. Any push restarts the count, and no trailing interrupt fires while the level is at or above the trigger.
- R8: A write to address 2 clears each status bit whose data bit is 1 and leaves the other bits unchanged. If a cause is raised in the same cycle as its clear, the bit stays set.
- R9: `irq` is high exactly when some status bit and the same bit of the enable mask (address 1, bits [6:0]) are both 1. It changes at the same edge as the status or mask write that causes the change.
- R10: A queue whose enable is 0 is emptied. While it stays disabled, pushes and pops to it are ignored and raise no status bits.
- R11: A push and a pop in the same cycle on a full transmit queue both take effect. The level stays at the depth and bit 3 is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Masked interrupt request |
| eng_tx_pop | input | 1 | Engine takes one transmit byte |
| eng_tx_data | output | 8 | Transmit byte, valid the cycle after `eng_tx_pop` |
| eng_rx_push | input | 1 | Engine delivers one receive byte |
| eng_rx_data | input | 8 | Receive byte delivered with `eng_rx_push` |

## Verification
A status clear written to address 2 can land in the same cycle as a new cause for the same bit. The bench provokes this by filling the receive queue and then issuing the receive-overrun push and the write-one-to-clear of bit 5 on one clock edge. The bit must still read as set afterwards, and only a later clear on its own removes it. The second collision is a transmit-data write and an engine pop on the same edge with the transmit queue full. The bench judges it by the level holding at the depth, bit 3 staying clear, and the oldest byte leaving first followed at the end by the new byte.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
  localparam int IRQ_W = 7;
  localparam int FIELD_W = 7;

  localparam int B_TX_LOW  = 0;
  localparam int B_RX_HIGH = 1;
  localparam int B_TX_UNF  = 2;
  localparam int B_TX_OVF  = 3;
  localparam int B_RX_UNF  = 4;
  localparam int B_RX_OVF  = 5;
  localparam int B_TRAIL   = 6;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_IEN   = 3'd1;
  localparam logic [2:0] A_ISTAT = 3'd2;
  localparam logic [2:0] A_QSTAT = 3'd3;
  localparam logic [2:0] A_TXD   = 3'd4;
  localparam logic [2:0] A_RXD   = 3'd5;
  localparam logic [2:0] A_TRAIL = 3'd6;

  localparam int C_RX_EN  = 0;
  localparam int C_TX_EN  = 1;
  localparam int C_RX_TRG = 4;
  localparam int C_TX_TRG = 16;
endpackage

// File: rtl/i2cf_fifo.sv
module i2cf_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DW-1:0]              push_data,
  input  logic                       pop,
  output logic [DW-1:0]              pop_data,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty,
  output logic                       ovf,
  output logic                       unf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == LW'(DEPTH));
  assign empty   = (cnt == '0);
  assign level   = cnt;
  assign do_pop  = pop & ~flush & ~empty;
  assign do_push = push & ~flush & (~full | do_pop);
  assign ovf     = push & ~flush & full & ~do_pop;
  assign unf     = pop & ~flush & empty;

  // storage array, no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  // registered read port; an empty or refused pop yields zero
  always_ff @(posedge clk) begin
    if (rst) pop_data <= '0;
    else if (pop) pop_data <= do_pop ? mem[rd_ptr] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/i2cf_trail.sv
module i2cf_trail #(
  parameter int LW = 7,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          push,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] trig,
  input  logic [TW-1:0] limit,
  output logic          fire
);
  // one spare bit lets the counter park past the limit after firing
  logic [TW:0] idle;
  logic        waiting;

  assign waiting = enable & (level != '0) & (level < trig);
  assign fire    = waiting & ~push & (idle == {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || !enable || push || level == '0) idle <= '0;
    else if (idle <= {1'b0, limit}) idle <= idle + 1'b1;
  end
endmodule

// File: rtl/i2cf_irq.sv
module i2cf_irq #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cause,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] en_next,
  output logic [N-1:0] status,
  output logic         irq
);
  logic [N-1:0] status_d;

  // a cause in the clearing cycle survives the clear
  assign status_d = (status & ~(clr_we ? clr_mask : '0)) | cause;

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_d;
      irq    <= |(status_d & en_next);
    end
  end
endmodule

// File: rtl/i2c_byte_fifos.sv
module i2c_byte_fifos
  import i2cf_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int TRAIL_W = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  input  logic        eng_tx_pop,
  output logic [7:0]  eng_tx_data,
  input  logic        eng_rx_push,
  input  logic [7:0]  eng_rx_data
);
  localparam int LW = $clog2(DEPTH+1);

  logic               tx_en, rx_en;
  logic [FIELD_W-1:0] tx_trig, rx_trig;
  logic [IRQ_W-1:0]   ien, ien_d, istat, cause;
  logic [TRAIL_W-1:0] trail_lim;

  logic wr_ctl, wr_ien, wr_istat, wr_trail, host_tx_push, host_rx_pop;
  logic [LW-1:0]      tx_lvl, rx_lvl;
  logic [FIELD_W-1:0] tx_lvl7, rx_lvl7;
  logic tx_full, tx_empty, tx_ovf, tx_unf;
  logic rx_full, rx_empty, rx_ovf, rx_unf;
  logic [7:0] rx_rd_byte;
  logic trail_fire;
  logic [31:0] ctl_word, qstat_word, rd_mux, rdata_q;
  logic rd_rx_q;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata;

  assign wr_ctl       = reg_wr && reg_addr == A_CTRL;
  assign wr_ien       = reg_wr && reg_addr == A_IEN;
  assign wr_istat     = reg_wr && reg_addr == A_ISTAT;
  assign wr_trail     = reg_wr && reg_addr == A_TRAIL;
  assign host_tx_push = reg_wr && reg_addr == A_TXD;
  assign host_rx_pop  = reg_rd && reg_addr == A_RXD;
  assign ien_d        = wr_ien ? reg_wdata[IRQ_W-1:0] : ien;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en     <= 1'b0;
      rx_en     <= 1'b0;
      tx_trig   <= '0;
      rx_trig   <= '0;
      ien       <= '0;
      trail_lim <= '0;
    end else begin
      if (wr_ctl) begin
        rx_en   <= reg_wdata[C_RX_EN];
        tx_en   <= reg_wdata[C_TX_EN];
        rx_trig <= reg_wdata[C_RX_TRG +: FIELD_W];
        tx_trig <= reg_wdata[C_TX_TRG +: FIELD_W];
      end
      ien <= ien_d;
      if (wr_trail) trail_lim <= reg_wdata[TRAIL_W-1:0];
    end
  end

  i2cf_fifo #(.DEPTH(DEPTH), .DW(8)) u_txq (
    .clk(clk), .rst(rst), .flush(!tx_en),
    .push(host_tx_push), .push_data(reg_wdata[7:0]),
    .pop(eng_tx_pop), .pop_data(eng_tx_data),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty),
    .ovf(tx_ovf), .unf(tx_unf)
  );

  i2cf_fifo #(.DEPTH(DEPTH), .DW(8)) u_rxq (
    .clk(clk), .rst(rst), .flush(!rx_en),
    .push(eng_rx_push), .push_data(eng_rx_data),
    .pop(host_rx_pop), .pop_data(rx_rd_byte),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty),
    .ovf(rx_ovf), .unf(rx_unf)
  );

  assign tx_lvl7 = FIELD_W'(tx_lvl);
  assign rx_lvl7 = FIELD_W'(rx_lvl);

  i2cf_trail #(.LW(FIELD_W), .TW(TRAIL_W)) u_trail (
    .clk(clk), .rst(rst), .enable(rx_en), .push(eng_rx_push),
    .level(rx_lvl7), .trig(rx_trig), .limit(trail_lim), .fire(trail_fire)
  );

  always_comb begin
    cause            = '0;
    cause[B_TX_LOW]  = tx_en && (tx_lvl7 <= tx_trig);
    cause[B_RX_HIGH] = rx_en && (rx_lvl7 >= rx_trig);
    cause[B_TX_UNF]  = tx_unf;
    cause[B_TX_OVF]  = tx_ovf;
    cause[B_RX_UNF]  = rx_unf;
    cause[B_RX_OVF]  = rx_ovf;
    cause[B_TRAIL]   = trail_fire;
  end

  i2cf_irq #(.N(IRQ_W)) u_irq (
    .clk(clk), .rst(rst), .cause(cause),
    .clr_we(wr_istat), .clr_mask(reg_wdata[IRQ_W-1:0]),
    .en_next(ien_d), .status(istat), .irq(irq)
  );

  always_comb begin
    ctl_word                           = '0;
    ctl_word[C_RX_EN]                  = rx_en;
    ctl_word[C_TX_EN]                  = tx_en;
    ctl_word[C_RX_TRG +: FIELD_W]      = rx_trig;
    ctl_word[C_TX_TRG +: FIELD_W]      = tx_trig;
    qstat_word = {7'd0, rx_empty, rx_full, rx_lvl7, 7'd0, tx_empty, tx_full, tx_lvl7};
    case (reg_addr)
      A_CTRL:  rd_mux = ctl_word;
      A_IEN:   rd_mux = 32'(ien);
      A_ISTAT: rd_mux = 32'(istat);
      A_QSTAT: rd_mux = qstat_word;
      A_TRAIL: rd_mux = 32'(trail_lim);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      rd_rx_q <= 1'b0;
    end else if (reg_rd) begin
      rdata_q <= rd_mux;
      rd_rx_q <= (reg_addr == A_RXD);
    end
  end

  // receive bytes come straight from the queue's own read register
  assign reg_rdata = rd_rx_q ? {24'd0, rx_rd_byte} : rdata_q;
endmodule

// File: rtl/i2c_byte_fifos_chk.sv
module i2c_byte_fifos_chk #(
  parameter int DEPTH = 64
) (
  input logic       clk,
  input logic       rst,
  input logic       tx_en,
  input logic [6:0] tx_lvl7,
  input logic [6:0] rx_lvl7,
  input logic [6:0] rx_trig,
  input logic [6:0] istat,
  input logic [6:0] ien,
  input logic       irq,
  input logic       host_tx_push,
  input logic       eng_tx_pop,
  input logic [7:0] eng_tx_data
);
  p_lvl_bound_r2: assert property (@(posedge clk) disable iff (rst)
    (tx_lvl7 <= 7'(DEPTH)) && (rx_lvl7 <= 7'(DEPTH)));

  p_ovf_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_en && tx_lvl7 == 7'(DEPTH) && host_tx_push && !eng_tx_pop)
    |=> (tx_lvl7 == 7'(DEPTH) && istat[3]));

  p_unf_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_en && tx_lvl7 == 7'd0 && eng_tx_pop) |=> (eng_tx_data == 8'h00 && istat[2]));

  p_trail_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(istat[6]) |-> ($past(rx_lvl7) != 7'd0 && $past(rx_lvl7) < $past(rx_trig)));

  p_irq_mask_r9: assert property (@(posedge clk) disable iff (rst)
    irq == |(istat & ien));

  p_flush_r10: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> tx_lvl7 == 7'd0);

  p_full_pushpop_r11: assert property (@(posedge clk) disable iff (rst)
    (tx_en && tx_lvl7 == 7'(DEPTH) && host_tx_push && eng_tx_pop) |=> tx_lvl7 == 7'(DEPTH));
endmodule

bind i2c_byte_fifos i2c_byte_fifos_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .tx_en(tx_en), .tx_lvl7(tx_lvl7), .rx_lvl7(rx_lvl7),
  .rx_trig(rx_trig), .istat(istat), .ien(ien), .irq(irq),
  .host_tx_push(host_tx_push), .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data)
);

// File: tb/i2c_byte_fifos_bench.sv
module i2c_byte_fifos_bench;
  localparam int DEPTH = 64;
  localparam logic [2:0] CTRL = 3'd0, IEN = 3'd1, ISTAT = 3'd2, QSTAT = 3'd3;
  localparam logic [2:0] TXD = 3'd4, RXD = 3'd5, TRL = 3'd6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        eng_tx_pop = 1'b0;
  logic [7:0]  eng_tx_data;
  logic        eng_rx_push = 1'b0;
  logic [7:0]  eng_rx_data = '0;

  int n_chk = 0;
  int n_err = 0;

  i2c_byte_fifos #(.DEPTH(DEPTH)) u_i2c_byte_fifos (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input logic rxe, input logic txe,
                                      input logic [6:0] rxt, input logic [6:0] txt);
    return (32'(txt) << 16) | (32'(rxt) << 4) | (32'(txe) << 1) | 32'(rxe);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk); eng_rx_push = 1'b1; eng_rx_data = b;
    @(negedge clk); eng_rx_push = 1'b0;
  endtask

  task automatic pop_tx(output logic [7:0] b);
    @(negedge clk); eng_tx_pop = 1'b1;
    @(negedge clk); eng_tx_pop = 1'b0; b = eng_tx_data;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(QSTAT, d); chk("R1 queue status", d, 32'h0100_0100);
    rd(ISTAT, d); chk("R1 int status", d, 32'h0);
    rd(CTRL, d);  chk("R1 control", d, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_order;
    logic [31:0] d; logic [7:0] b;
    wr(CTRL, ctl(1, 1, 0, 0));
    wr(TXD, 32'hA1); wr(TXD, 32'hB2); wr(TXD, 32'hC3);
    rd(QSTAT, d); chk("R2 tx level field", d, 32'h0100_0003);
    pop_tx(b); chk("R2 tx order 1", 32'(b), 32'hA1);
    pop_tx(b); chk("R2 tx order 2", 32'(b), 32'hB2);
    pop_tx(b); chk("R2 tx order 3", 32'(b), 32'hC3);
    push_rx(8'h5A); push_rx(8'h6B);
    rd(QSTAT, d); chk("R2 rx level field", d, 32'h0002_0100);
    rd(RXD, d); chk("R2 rx order 1", d, 32'h5A);
    rd(RXD, d); chk("R2 rx order 2", d, 32'h6B);
    wr(CTRL, 32'h0);
  endtask

  task automatic t_tx_low;
    logic [31:0] d; logic [7:0] b;
    wr(CTRL, ctl(0, 1, 0, 2));
    wr(TXD, 1); wr(TXD, 2); wr(TXD, 3);
    wr(ISTAT, 32'h7F);
    rd(ISTAT, d); chk("R3 tx low clear above trigger", d & 32'h1, 32'h0);
    pop_tx(b);
    rd(ISTAT, d); chk("R3 tx low at trigger", d & 32'h1, 32'h1);
    wr(CTRL, 32'h0);
  endtask

  task automatic t_rx_high;
    logic [31:0] d;
    wr(CTRL, ctl(1, 0, 4, 0));
    push_rx(1); push_rx(2); push_rx(3);
    wr(ISTAT, 32'h7F);
    rd(ISTAT, d); chk("R4 rx high below trigger", d & 32'h2, 32'h0);
    push_rx(4);
    rd(ISTAT, d); chk("R4 rx high at trigger", d & 32'h2, 32'h2);
    wr(CTRL, 32'h0);
  endtask

  task automatic t_overrun;
    logic [31:0] d; logic [7:0] b, first;
    wr(CTRL, ctl(0, 1, 0, 0));
    for (int i = 0; i < DEPTH; i++) wr(TXD, 32'(i));
    wr(ISTAT, 32'h7F);
    wr(TXD, 32'hEE);
    rd(ISTAT, d); chk("R5 tx overrun bit3", d & 32'h8, 32'h8);
    rd(QSTAT, d); chk("R5 tx level stays full", d & 32'h1FF, 32'h0C0);
    pop_tx(first);
    for (int i = 1; i < DEPTH; i++) pop_tx(b);
    chk("R5 first byte kept", 32'(first), 32'h00);
    chk("R5 dropped byte absent", 32'(b), 32'(DEPTH-1));
    wr(CTRL, ctl(1, 0, 0, 0));
    for (int i = 0; i <= DEPTH; i++) push_rx(8'(i));
    rd(ISTAT, d); chk("R5 rx overrun bit5", d & 32'h20, 32'h20);
    rd(QSTAT, d); chk("R5 rx level stays full", d & 32'h01FF_0000, 32'h00C0_0000);
    wr(CTRL, 32'h0);
  endtask

  task automatic t_underrun;
    logic [31:0] d; logic [7:0] b;
    wr(CTRL, ctl(1, 1, 0, 0));
    wr(ISTAT, 32'h7F);
    pop_tx(b); chk("R6 empty tx pop gives zero", 32'(b), 32'h0);
    rd(ISTAT, d); chk("R6 tx underrun bit2", d & 32'h4, 32'h4);
    rd(RXD, d); chk("R6 empty rx read gives zero", d, 32'h0);
    rd(ISTAT, d); chk("R6 rx underrun bit4", d & 32'h10, 32'h10);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    wr(ISTAT, 32'h04);
    rd(ISTAT, d); chk("R8 selective clear", d & 32'h14, 32'h10);
    for (int i = 0; i < DEPTH; i++) push_rx(8'(i));
    push_rx(8'hFF);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ISTAT; reg_wdata = 32'h20; eng_rx_push = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; eng_rx_push = 1'b0;
    rd(ISTAT, d); chk("R8 set wins over clear", d & 32'h20, 32'h20);
    wr(ISTAT, 32'h20);
    rd(ISTAT, d); chk("R8 clear alone", d & 32'h20, 32'h0);
    wr(CTRL, 32'h0);
  endtask

  task automatic t_irq;
    logic [7:0] b;
    wr(CTRL, ctl(1, 1, 0, 0));
    wr(ISTAT, 32'h7F);
    pop_tx(b);
    chk("R9 masked cause keeps irq low", 32'(irq), 32'h0);
    wr(IEN, 32'h04); chk("R9 unmasked cause raises irq", 32'(irq), 32'h1);
    wr(IEN, 32'h10); chk("R9 other mask bit", 32'(irq), 32'h0);
    wr(IEN, 32'h04);
    wr(ISTAT, 32'h04); chk("R9 irq drops on clear", 32'(irq), 32'h0);
    wr(IEN, 32'h0);
    wr(CTRL, 32'h0);
  endtask

  task automatic t_trailing;
    logic [31:0] d;
    wr(IEN, 32'h40);
    wr(TRL, 32'd3);
    wr(CTRL, ctl(1, 0, 8, 0));
    wr(ISTAT, 32'h7F);
    push_rx(8'h11);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R7 no trailing before count", 32'(irq), 32'h0);
    end
    @(negedge clk); chk("R7 trailing at count+1", 32'(irq), 32'h1);
    wr(ISTAT, 32'h40);
    push_rx(8'h22);
    @(negedge clk);
    push_rx(8'h33);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R7 push restarts count", 32'(irq), 32'h0);
    end
    @(negedge clk); chk("R7 trailing after restart", 32'(irq), 32'h1);
    for (int i = 0; i < 5; i++) push_rx(8'(i));
    wr(ISTAT, 32'h40);
    for (int i = 0; i < 8; i++) @(negedge clk);
    rd(ISTAT, d); chk("R7 none at trigger", d & 32'h40, 32'h0);
    wr(IEN, 32'h0);
    wr(CTRL, 32'h0);
  endtask

  task automatic t_disable;
    logic [31:0] d; logic [7:0] b;
    wr(CTRL, ctl(1, 0, 0, 0));
    push_rx(1); push_rx(2); push_rx(3);
    wr(CTRL, 32'h0);
    rd(QSTAT, d); chk("R10 disable empties rx", d & 32'h01FF_0000, 32'h0100_0000);
    wr(ISTAT, 32'h7F);
    push_rx(8'h44);
    rd(QSTAT, d); chk("R10 push ignored while off", d & 32'h01FF_0000, 32'h0100_0000);
    rd(ISTAT, d); chk("R10 no flags while off", d & 32'h3F, 32'h0);
    wr(TXD, 32'h55);
    wr(CTRL, ctl(0, 1, 0, 0));
    pop_tx(b); chk("R10 tx write dropped while off", 32'(b), 32'h0);
    wr(CTRL, 32'h0);
  endtask

  task automatic t_pushpop_full;
    logic [31:0] d; logic [7:0] b;
    wr(CTRL, ctl(0, 1, 0, 0));
    for (int i = 0; i < DEPTH; i++) wr(TXD, 32'(i + 16));
    wr(ISTAT, 32'h7F);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = TXD; reg_wdata = 32'h99; eng_tx_pop = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; eng_tx_pop = 1'b0; b = eng_tx_data;
    chk("R11 oldest byte out", 32'(b), 32'h10);
    rd(QSTAT, d); chk("R11 level stays full", d & 32'h1FF, 32'h0C0);
    rd(ISTAT, d); chk("R11 no overrun", d & 32'h8, 32'h0);
    for (int i = 0; i < DEPTH; i++) pop_tx(b);
    chk("R11 new byte last", 32'(b), 32'h99);
    wr(CTRL, 32'h0);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_order();
    t_tx_low();
    t_rx_high();
    t_overrun();
    t_underrun();
    t_w1c();
    t_irq();
    t_trailing();
    t_disable();
    t_pushpop_full();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end
endmodule